// File: doc/BRIEF.md
# Row-major to column-page pixel transposer

This block converts a packed one-bit-per-pixel image, held row after row in a line buffer, into the column-byte stream that a page-organised monochrome display controller consumes. A page is a horizontal strip eight pixel rows high. Each output byte holds the eight vertically stacked pixels of a single column inside one page, with the top row of the strip in the least significant bit.

A transfer is started with a one-cycle request that carries the display height, the top and bottom edges of the update rectangle and its width. The block first snaps the rectangle to page boundaries. It then fetches up to eight row bytes of one eight-column group into a small register file through a synchronous read port with one cycle of latency. It emits one byte per column on a valid/ready stream and moves on to the next group and then to the next page. The line buffer holds the rectangle only: its row 0 is the snapped top row, and each row takes the width rounded up to whole bytes.

Top module: `xpose_col_pager`

## Requirements
- R1: While reset is held and after its release, with no request, `busy_o`, `rd_en_o` and `out_valid_o` are low.
- R2: The top edge is rounded down to a multiple of 8. The bottom edge is rounded up to a multiple of 8 and then limited to the display height. Rows = snapped bottom − snapped top, pitch = ceil(width/8). The byte for buffer row r and column group g is read at address r·pitch + g, and `rd_data_i` is taken one cycle after `rd_en_o`.
- R3: For page p and column j, output bit k equals bit (j mod 8) of buffer byte (8p+k)·pitch + j/8. Bit 0 is the first column of a byte.
- R4: Bytes leave in page order, columns left to right within each page. ceil(rows/8)·width bytes are sent, `out_last_o` marks only the final one, and `busy_o` is low on the edge after it is accepted.
- R5: On a last page holding fewer than 8 rows, the bits for the missing rows are 0.
- R6: Each needed row byte is read exactly once per transfer (rows·pitch reads in total), and no read is issued while a byte is offered.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the offered byte and `out_last_o` hold, and no byte is lost or repeated.
- R8: A request while busy is ignored. A request with width 0 or with zero snapped rows is ignored, and the block stays idle.
- R9: After a request is accepted, `out_valid_o` first rises on the (r+1)-th rising edge after the accepting edge, where r = min(8, rows).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, taken when idle |
| disp_height_i | input | H_BITS | Display height in rows |
| rect_top_i | input | H_BITS | Top edge of the rectangle (inclusive) |
| rect_bot_i | input | H_BITS | Bottom edge of the rectangle (exclusive) |
| rect_width_i | input | W_BITS | Rectangle width in columns |
| busy_o | output | 1 | Transfer in progress |
| rd_en_o | output | 1 | Line buffer read strobe |
| rd_addr_o | output | ADDR_BITS | Line buffer byte address |
| rd_data_i | input | 8 | Line buffer data, one cycle after the strobe |
| out_valid_o | output | 1 | Column byte offered |
| out_ready_i | input | 1 | Consumer accepts the byte |
| out_data_o | output | 8 | Column byte, bit k = row k of the page |
| out_last_o | output | 1 | Final byte of the transfer |

## Verification
The first column byte is due r+1 rising edges after the accepting edge, and every later group repeats the same fetch-then-emit gap. A stalled byte must be unchanged one edge later, and `busy_o` must fall on the edge that takes the final byte. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the accepting edge to place the latency check, and it records a byte only when valid and its own ready were both high across the intervening rising edge, so the comparison against the arithmetic reference never depends on stall timing.

// File: rtl/xpose_pkg.sv
package xpose_pkg;

  localparam int STRIP_ROWS = 8;

  typedef enum logic [1:0] {
    WALK_IDLE,
    WALK_FETCH,
    WALK_DRAIN,
    WALK_EMIT
  } walk_state_e;

  // Snap an edge down to a page boundary.
  function automatic int snap_down(int v);
    return (v / STRIP_ROWS) * STRIP_ROWS;
  endfunction

  // Snap an edge up to a page boundary, never beyond the display height.
  function automatic int snap_up_limited(int v, int lim);
    int up;
    up = ((v + STRIP_ROWS - 1) / STRIP_ROWS) * STRIP_ROWS;
    return (up > lim) ? lim : up;
  endfunction

  function automatic int bytes_per_row(int w);
    return (w + 7) / 8;
  endfunction

  function automatic int strip_count(int rows);
    return (rows + STRIP_ROWS - 1) / STRIP_ROWS;
  endfunction

  // Rows present in a given page of a rectangle that has 'rows' rows.
  function automatic int rows_in_strip(int rows, int page);
    int rem;
    rem = rows - page * STRIP_ROWS;
    if (rem < 0) return 0;
    return (rem > STRIP_ROWS) ? STRIP_ROWS : rem;
  endfunction

  function automatic int buf_addr(int row, int pitch, int grp);
    return row * pitch + grp;
  endfunction

endpackage

// File: rtl/xpose_geom.sv
module xpose_geom
  import xpose_pkg::*;
#(
  parameter int W_BITS     = 8,
  parameter int H_BITS     = 7,
  parameter int PITCH_BITS = 5,
  parameter int PG_BITS    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [H_BITS-1:0]     disp_h_i,
  input  logic [H_BITS-1:0]     top_i,
  input  logic [H_BITS-1:0]     bot_i,
  input  logic [W_BITS-1:0]     width_i,
  output logic                  empty_o,
  output logic [W_BITS-1:0]     width_o,
  output logic [PITCH_BITS-1:0] pitch_o,
  output logic [H_BITS-1:0]     rows_o,
  output logic [PG_BITS-1:0]    pages_o
);

  int top_snap;
  int bot_snap;
  int rows_c;

  always_comb begin
    top_snap = snap_down(int'(top_i));
    bot_snap = snap_up_limited(int'(bot_i), int'(disp_h_i));
    rows_c   = (bot_snap > top_snap) ? (bot_snap - top_snap) : 0;
    empty_o  = (rows_c == 0) || (width_i == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_o <= '0;
      pitch_o <= '0;
      rows_o  <= '0;
      pages_o <= '0;
    end else if (load_i) begin
      width_o <= width_i;
      pitch_o <= PITCH_BITS'(bytes_per_row(int'(width_i)));
      rows_o  <= H_BITS'(rows_c);
      pages_o <= PG_BITS'(strip_count(rows_c));
    end
  end

endmodule

// File: rtl/xpose_walk.sv
module xpose_walk
  import xpose_pkg::*;
#(
  parameter int W_BITS     = 8,
  parameter int H_BITS     = 7,
  parameter int PITCH_BITS = 5,
  parameter int PG_BITS    = 4,
  parameter int ADDR_BITS  = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  empty_i,
  input  logic [W_BITS-1:0]     width_i,
  input  logic [PITCH_BITS-1:0] pitch_i,
  input  logic [H_BITS-1:0]     rows_i,
  input  logic [PG_BITS-1:0]    pages_i,
  input  logic                  out_ready_i,
  output logic                  load_o,
  output logic                  busy_o,
  output logic                  rd_en_o,
  output logic [ADDR_BITS-1:0]  rd_addr_o,
  output logic [2:0]            rd_row_o,
  output logic [3:0]            strip_rows_o,
  output logic [2:0]            col_o,
  output logic                  out_valid_o,
  output logic                  out_last_o,
  output logic                  xfer_o
);

  walk_state_e           state_q;
  logic [PG_BITS-1:0]    page_q;
  logic [PITCH_BITS-1:0] grp_q;
  logic [2:0]            fk_q;
  logic [2:0]            col_q;

  int   strip_rows_c;
  int   col_abs;
  logic fetch_last;
  logic col_end;
  logic grp_last;
  logic page_last;

  always_comb begin
    load_o       = (state_q == WALK_IDLE) && start_i && !empty_i;
    busy_o       = (state_q != WALK_IDLE);
    strip_rows_c = rows_in_strip(int'(rows_i), int'(page_q));
    strip_rows_o = 4'(strip_rows_c);
    fetch_last   = ({1'b0, fk_q} == (strip_rows_o - 4'd1));
    col_abs      = int'(grp_q) * 8 + int'(col_q);
    col_end      = (col_q == 3'd7) || (col_abs == int'(width_i) - 1);
    grp_last     = (int'(grp_q) == int'(pitch_i) - 1);
    page_last    = (int'(page_q) == int'(pages_i) - 1);
    rd_en_o      = (state_q == WALK_FETCH);
    rd_addr_o    = ADDR_BITS'(buf_addr(int'(page_q) * STRIP_ROWS + int'(fk_q),
                                       int'(pitch_i), int'(grp_q)));
    rd_row_o     = fk_q;
    col_o        = col_q;
    out_valid_o  = (state_q == WALK_EMIT);
    xfer_o       = out_valid_o && out_ready_i;
    out_last_o   = out_valid_o && col_end && grp_last && page_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      page_q  <= '0;
      grp_q   <= '0;
      fk_q    <= '0;
      col_q   <= '0;
    end else begin
      unique case (state_q)
        WALK_IDLE: begin
          if (load_o) begin
            state_q <= WALK_FETCH;
            page_q  <= '0;
            grp_q   <= '0;
            fk_q    <= '0;
            col_q   <= '0;
          end
        end
        WALK_FETCH: begin
          if (fetch_last) state_q <= WALK_DRAIN;
          else            fk_q    <= fk_q + 3'd1;
        end
        WALK_DRAIN: begin
          state_q <= WALK_EMIT;
          col_q   <= '0;
        end
        WALK_EMIT: begin
          if (xfer_o) begin
            if (col_end) begin
              fk_q  <= '0;
              col_q <= '0;
              if (grp_last) begin
                grp_q <= '0;
                if (page_last) begin
                  state_q <= WALK_IDLE;
                end else begin
                  page_q  <= page_q + 1'b1;
                  state_q <= WALK_FETCH;
                end
              end else begin
                grp_q   <= grp_q + 1'b1;
                state_q <= WALK_FETCH;
              end
            end else begin
              col_q <= col_q + 3'd1;
            end
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xpose_strip_buf.sv
module xpose_strip_buf
  import xpose_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en_i,
  input  logic [2:0] rd_row_i,
  input  logic [7:0] rd_data_i,
  input  logic [3:0] strip_rows_i,
  input  logic [2:0] col_i,
  output logic [7:0] byte_o
);

  logic       cap_v_q;
  logic [2:0] cap_row_q;
  logic [7:0] line_q [STRIP_ROWS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_v_q   <= 1'b0;
      cap_row_q <= '0;
      for (int i = 0; i < STRIP_ROWS; i++) line_q[i] <= '0;
    end else begin
      cap_v_q   <= rd_en_i;
      cap_row_q <= rd_row_i;
      if (cap_v_q) line_q[cap_row_q] <= rd_data_i;
    end
  end

  // Rows past the end of a short strip read as zero.
  for (genvar k = 0; k < STRIP_ROWS; k++) begin : g_gather
    assign byte_o[k] = (4'(k) < strip_rows_i) ? line_q[k][col_i] : 1'b0;
  end

endmodule

// File: rtl/xpose_col_pager.sv
module xpose_col_pager
  import xpose_pkg::*;
#(
  parameter int MAX_W = 128,
  parameter int MAX_H = 64,
  localparam int W_BITS     = $clog2(MAX_W + 1),
  localparam int H_BITS     = $clog2(MAX_H + 1),
  localparam int PITCH_MAX  = (MAX_W + 7) / 8,
  localparam int PITCH_BITS = $clog2(PITCH_MAX + 1),
  localparam int PG_MAX     = (MAX_H + STRIP_ROWS - 1) / STRIP_ROWS,
  localparam int PG_BITS    = $clog2(PG_MAX + 1),
  localparam int ADDR_BITS  = $clog2(MAX_H * PITCH_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [H_BITS-1:0]    disp_height_i,
  input  logic [H_BITS-1:0]    rect_top_i,
  input  logic [H_BITS-1:0]    rect_bot_i,
  input  logic [W_BITS-1:0]    rect_width_i,
  output logic                 busy_o,
  output logic                 rd_en_o,
  output logic [ADDR_BITS-1:0] rd_addr_o,
  input  logic [7:0]           rd_data_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [7:0]           out_data_o,
  output logic                 out_last_o
);

  logic                  load_w;
  logic                  empty_w;
  logic [W_BITS-1:0]     width_w;
  logic [PITCH_BITS-1:0] pitch_w;
  logic [H_BITS-1:0]     rows_w;
  logic [PG_BITS-1:0]    pages_w;
  logic [2:0]            rd_row_w;
  logic [3:0]            strip_rows_w;
  logic [2:0]            col_w;
  logic                  xfer_w;
  logic [ADDR_BITS:0]    read_span_w;

  assign read_span_w = (ADDR_BITS + 1)'(int'(rows_w) * int'(pitch_w));

  xpose_geom #(
    .W_BITS(W_BITS), .H_BITS(H_BITS), .PITCH_BITS(PITCH_BITS), .PG_BITS(PG_BITS)
  ) u_geom (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_w),
    .disp_h_i (disp_height_i),
    .top_i    (rect_top_i),
    .bot_i    (rect_bot_i),
    .width_i  (rect_width_i),
    .empty_o  (empty_w),
    .width_o  (width_w),
    .pitch_o  (pitch_w),
    .rows_o   (rows_w),
    .pages_o  (pages_w)
  );

  xpose_walk #(
    .W_BITS(W_BITS), .H_BITS(H_BITS), .PITCH_BITS(PITCH_BITS),
    .PG_BITS(PG_BITS), .ADDR_BITS(ADDR_BITS)
  ) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .empty_i      (empty_w),
    .width_i      (width_w),
    .pitch_i      (pitch_w),
    .rows_i       (rows_w),
    .pages_i      (pages_w),
    .out_ready_i  (out_ready_i),
    .load_o       (load_w),
    .busy_o       (busy_o),
    .rd_en_o      (rd_en_o),
    .rd_addr_o    (rd_addr_o),
    .rd_row_o     (rd_row_w),
    .strip_rows_o (strip_rows_w),
    .col_o        (col_w),
    .out_valid_o  (out_valid_o),
    .out_last_o   (out_last_o),
    .xfer_o       (xfer_w)
  );

  xpose_strip_buf u_strip (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en_i      (rd_en_o),
    .rd_row_i     (rd_row_w),
    .rd_data_i    (rd_data_i),
    .strip_rows_i (strip_rows_w),
    .col_i        (col_w),
    .byte_o       (out_data_o)
  );

endmodule

// File: rtl/xpose_checker.sv
module xpose_checker #(
  parameter int ADDR_BITS = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 busy_o,
  input logic                 rd_en_o,
  input logic [ADDR_BITS-1:0] rd_addr_o,
  input logic [ADDR_BITS:0]   read_span,
  input logic                 out_valid_o,
  input logic                 out_ready_i,
  input logic [7:0]           out_data_o,
  input logic                 out_last_o,
  input logic                 xfer
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rd_en_o && !out_valid_o)); // R1

  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> ({1'b0, rd_addr_o} < read_span)); // R2

  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && out_last_o) |=> !busy_o); // R4

  AST_NO_READ_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !rd_en_o); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o))); // R7

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i)); // R8

endmodule

bind xpose_col_pager xpose_checker #(.ADDR_BITS(ADDR_BITS)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .rd_en_o     (rd_en_o),
  .rd_addr_o   (rd_addr_o),
  .read_span   (read_span_w),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o),
  .xfer        (xfer_w)
);

// File: tb/tb_xpose_col_pager.sv
`timescale 1ns/1ps
module tb_xpose_col_pager;

  localparam int MAX_W      = 20;
  localparam int MAX_H      = 24;
  localparam int W_BITS     = $clog2(MAX_W + 1);
  localparam int H_BITS     = $clog2(MAX_H + 1);
  localparam int PITCH_MAX  = (MAX_W + 7) / 8;
  localparam int ADDR_BITS  = $clog2(MAX_H * PITCH_MAX + 1);
  localparam int MEM_DEPTH  = 1 << ADDR_BITS;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 start;
  logic [H_BITS-1:0]    disp_h;
  logic [H_BITS-1:0]    rect_top;
  logic [H_BITS-1:0]    rect_bot;
  logic [W_BITS-1:0]    rect_w;
  logic                 busy;
  logic                 rd_en;
  logic [ADDR_BITS-1:0] rd_addr;
  logic [7:0]           rd_data;
  logic                 out_valid;
  logic                 out_ready;
  logic [7:0]           out_data;
  logic                 out_last;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  logic [7:0] lfsr = 8'h5a;
  logic [7:0] mem [MEM_DEPTH];

  always #2 clk = ~clk;

  xpose_col_pager #(.MAX_W(MAX_W), .MAX_H(MAX_H)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .disp_height_i(disp_h), .rect_top_i(rect_top), .rect_bot_i(rect_bot),
    .rect_width_i(rect_w), .busy_o(busy), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_last_o(out_last)
  );

  // Line buffer model: data one cycle after the strobe (R2).
  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
      rd_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Reference column byte from the requirement text (R3, R5).
  function automatic logic [7:0] ref_byte(int p, int j, int rows, int pitch);
    logic [7:0] b;
    b = '0;
    for (int k = 0; k < 8; k++) begin
      int r;
      r = 8 * p + k;
      if (r < rows) b[k] = mem[r * pitch + j / 8][j % 8];
    end
    return b;
  endfunction

  task automatic run_case(input int h, input int top, input int bot, input int w,
                          input int seed, input bit stall);
    int top_s, up, bot_s, rows, pitch, pages, n_exp, pr0;
    int got, t, first;
    bit hold;
    logic [7:0] hold_data;
    logic hold_last;
    for (int a = 0; a < MEM_DEPTH; a++)
      mem[a] = 8'(((a * 29) + (seed * 53) + ((a >> 2) * 7)) ^ (seed * 3));
    top_s = (top / 8) * 8;
    up    = ((bot + 7) / 8) * 8;
    bot_s = (up > h) ? h : up;
    rows  = (bot_s > top_s) ? (bot_s - top_s) : 0;
    pitch = (w + 7) / 8;
    pages = (rows + 7) / 8;
    n_exp = (w == 0) ? 0 : pages * w;
    pr0   = (rows > 8) ? 8 : rows;

    @(negedge clk);
    disp_h   = H_BITS'(h);
    rect_top = H_BITS'(top);
    rect_bot = H_BITS'(bot);
    rect_w   = W_BITS'(w);
    start    = 1'b1;
    out_ready = 1'b1;
    rd_cnt   = 0;
    @(negedge clk);
    start = 1'b0;

    if (n_exp == 0) begin
      for (int i = 0; i < 4; i++) begin
        check(!busy && !rd_en && !out_valid, "R8", "empty request activity",
              int'(busy) + int'(rd_en) + int'(out_valid), 0);
        @(negedge clk);
      end
      return;
    end

    got = 0; t = 0; first = -1; hold = 0; hold_data = '0; hold_last = 1'b0;
    while (got < n_exp && t < 5000) begin
      if (hold)
        check(out_valid && out_data == hold_data && out_last == hold_last,
              "R7", "stalled byte", int'(out_data), int'(hold_data));
      if (out_valid && first < 0) begin
        first = t;
        check(first == pr0 + 1, "R9", "first valid edge", first, pr0 + 1);
      end
      // A second request during the transfer must change nothing (R8).
      if (t == 2) begin
        rect_w = W_BITS'(1); rect_top = '0; rect_bot = H_BITS'(8); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = stall ? (lfsr[0] | lfsr[2]) : 1'b1;
      if (out_valid && out_ready) begin
        int p, j;
        logic [7:0] e;
        p = got / w;
        j = got % w;
        e = ref_byte(p, j, rows, pitch);
        // R2 addressing and R4 ordering are covered by this comparison.
        check(out_data == e, (rows < 8 * (p + 1)) ? "R5" : "R3",
              $sformatf("byte page %0d col %0d", p, j), int'(out_data), int'(e));
        check(out_last == (got == n_exp - 1), "R4", "last flag",
              int'(out_last), int'(got == n_exp - 1));
        got++;
      end
      hold = out_valid && !out_ready;
      hold_data = out_data;
      hold_last = out_last;
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    out_ready = 1'b1;
    check(got == n_exp, "R4", "bytes received", got, n_exp);
    check(!busy, "R4", "busy after final byte", int'(busy), 0);
    check(rd_cnt == rows * pitch, "R6", "read count", rd_cnt, rows * pitch);
    @(negedge clk);
    check(!busy && !out_valid, "R8", "no restart from ignored request",
          int'(busy), 0);
  endtask

  initial begin
    int heights [3] = '{24, 13, 8};
    int widths  [6] = '{1, 5, 8, 9, 16, 20};
    int tops    [6] = '{0, 3, 8, 9, 16, 0};
    int bots    [6] = '{24, 10, 17, 13, 24, 1};
    int n;
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b0;
    disp_h = '0; rect_top = '0; rect_bot = '0; rect_w = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !rd_en && !out_valid, "R1", "state in reset",
          int'(busy) + int'(rd_en) + int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !rd_en && !out_valid, "R1", "idle after reset",
          int'(busy) + int'(rd_en) + int'(out_valid), 0);

    run_case(24, 0, 8, 0, 1, 1'b0);   // R8 width zero
    run_case(24, 8, 8, 12, 2, 1'b0);  // R8 zero rows after snapping
    run_case(13, 16, 24, 12, 3, 1'b0); // R2 clamp leaves nothing

    n = 0;
    foreach (heights[hi])
      foreach (widths[wi])
        foreach (tops[ri]) begin
          run_case(heights[hi], tops[ri], bots[ri], widths[wi], n + 7, n[0]);
          n++;
        end
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule